// File: doc/BRIEF.md
# Codec Clock and Frame Generator

This block produces the sample timing for a sigma-delta codec's serial port. It runs on the master clock. It derives three things from that clock: the oversampling clock, the serial shift clock (which has the same rate as the oversampling clock) and the frame sync. In crystal mode the master clock passes through three dividers in turn. The first is an integer divider. The second is a divider that also accepts half-integer ratios. The third is the oversampling divider, which sets how many shift clocks make up one sampling period. In external-clock mode the master clock itself serves as the oversampling clock.

All logic is synchronous to the master clock. The oversampling/shift clock appears as a single-cycle enable, `os_tick`, once per oversampling period. Divider settings come from a 16-bit configuration word, which is written with a one-cycle load strobe. In master mode the block drives an active-low frame sync. It marks a primary frame at the start of each sampling period and, when control transfers are enabled, a secondary frame halfway through. In slave mode the block drives no sync. It only classifies falling edges of an external sync as primary or secondary.

Top module: `codec_clkgen`

## Requirements
- R1: In crystal mode, any two consecutive `os_tick` intervals together last exactly 2·M·Q master-clock cycles.
- R2: When Q is a half-integer, the `os_tick` intervals alternate between M·floor(Q) and M·ceil(Q) cycles. When Q is an integer, every interval is M·Q cycles.
- R3: The integer divider ratio M is selected by the 3-bit code {cfg_word[13], cfg_word[12], cfg_word[8]}: 000→3, 001→4, 110→1, 111→2.
- R4: The fractional ratio Q is selected by cfg_word[11:9]: 000..011 → 5, 6, 7, 8 and 100..111 → 4.5, 5.5, 6.5, 7.5.
- R5: The oversampling ratio is selected by cfg_word[5:3]: 000→160, 001→192, 101→64, 110→96, 111→128. One sampling period lasts that many `os_tick`s.
- R6: In external-clock mode (`xtal_mode`=0), `os_tick` is high on every cycle out of reset.
- R7: After reset the settings are M=4, Q=6 and OVER=160, so in crystal mode one sampling period lasts 3840 cycles and one `os_tick` interval lasts 24 cycles.
- R8: In master mode, `fs_n` goes low at the start of each sampling period for exactly one oversampling period. `prim_strobe` pulses for one cycle at the same moment.
- R9: In master mode with `ctrl_mode`=1, a secondary sync (`fs_n` low, `sec_strobe` pulse) occurs OVER/2 `os_tick`s after each primary. With `ctrl_mode`=0, `sec_strobe` never fires.
- R10: In slave mode, `fs_n` stays high. Each falling edge of `ext_fs_n` produces one strobe. The first edge after reset is primary. With `ctrl_mode`=1 the strobes then alternate between primary and secondary; with `ctrl_mode`=0 every edge is primary.
- R11: A load carrying a reserved M code (01x, 10x) or a reserved oversampling code (010, 011, 100) leaves that setting unchanged. The other fields of the same word still take effect.
- R12: While `rst_n` is low, `os_tick`, `prim_strobe` and `sec_strobe` are low and `fs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_mode | input | 1 | 1: divide the master clock by M·Q; 0: use it directly as the oversampling clock |
| master | input | 1 | 1: generate frame sync; 0: follow `ext_fs_n` |
| ctrl_mode | input | 1 | Enables the mid-frame secondary sync |
| cfg_word | input | 16 | Configuration word carrying the M, Q and oversampling codes |
| cfg_load | input | 1 | One-cycle strobe that loads `cfg_word` |
| ext_fs_n | input | 1 | External active-low frame sync (slave mode) |
| os_tick | output | 1 | Oversampling/shift clock enable, one cycle per period |
| fs_n | output | 1 | Generated active-low frame sync (master mode) |
| prim_strobe | output | 1 | One-cycle pulse at a primary frame start |
| sec_strobe | output | 1 | One-cycle pulse at a secondary frame start |

## Verification
The bench sweeps every valid M and Q code pair and measures two consecutive shift-clock intervals. A half-integer divider that does not alternate, or alternates with the wrong phase lengths, shows a wrong pair sum or equal intervals. A decode error shows up as a scaled interval. In external-clock mode the bench walks through every valid oversampling code and times primary-to-secondary and secondary-to-primary spacing. A frame counter that wraps at the wrong count, or misplaces the midpoint, fails there. Loads with reserved codes are checked to leave the old ratio in force while the other field still changes. Slave runs confirm that the primary/secondary alternation starts on primary and that the generated sync stays quiet.

// File: rtl/ccg_pkg.sv
// Package: shared decode helpers for the codec clock generator.
// Assumes configuration codes as described in the brief (R3, R4, R5).
package ccg_pkg;

    // M ratio code valid check (R11)
    function automatic logic m_code_ok(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b001) || (c[2:1] == 2'b11);
    endfunction

    // M ratio decode (R3)
    function automatic logic [2:0] m_decode(input logic [2:0] c);
        case (c)
            3'b000:  return 3'd3;
            3'b001:  return 3'd4;
            3'b110:  return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

    // Twice the Q ratio, so half-integers stay integral (R4)
    function automatic logic [4:0] q2_decode(input logic [2:0] c);
        return c[2] ? (5'd9 + {1'b0, c[1:0], 1'b0}) : (5'd10 + {1'b0, c[1:0], 1'b0});
    endfunction

    // Oversampling code valid check (R11)
    function automatic logic over_code_ok(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b001) || (c >= 3'b101);
    endfunction

    // Oversampling ratio decode (R5)
    function automatic logic [7:0] over_decode(input logic [2:0] c);
        case (c)
            3'b000:  return 8'd160;
            3'b001:  return 8'd192;
            3'b101:  return 8'd64;
            3'b110:  return 8'd96;
            default: return 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/ccg_cfg_reg.sv
// Module: holds decoded divider settings loaded from the configuration word.
// Assumes cfg_load is a single-cycle strobe; reserved M or OVER codes are
// dropped field by field while other fields still load.
module ccg_cfg_reg
    import ccg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [15:0] word_i,
    output logic [2:0]  m_o,
    output logic [4:0]  q2_o,
    output logic [7:0]  over_o
);
    logic [2:0] m_code;
    logic [2:0] q_code;
    logic [2:0] o_code;

    assign m_code = {word_i[13], word_i[12], word_i[8]};
    assign q_code = word_i[11:9];
    assign o_code = word_i[5:3];

    // Settings register: reset defaults M=4, Q=6, OVER=160
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_o    <= 3'd4;
            q2_o   <= 5'd12;
            over_o <= 8'd160;
        end else if (load_i) begin
            if (m_code_ok(m_code))    m_o    <= m_decode(m_code);
            q2_o <= q2_decode(q_code);
            if (over_code_ok(o_code)) over_o <= over_decode(o_code);
        end
    end
endmodule

// File: rtl/ccg_int_div.sv
// Module: integer divider that emits one enable per DIV enabled input cycles.
// Assumes div_i >= 1; a ratio lowered mid-count wraps on the next enable.
module ccg_int_div #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last   = div_i - 1'b1;
    assign tick_o = en_i && (cnt >= last);

    // Count enabled cycles and wrap at the ratio
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (tick_o)  cnt <= '0;
        else if (en_i)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ccg_half_div.sv
// Module: divider whose ratio is given doubled (q2_i = 2Q), so it also takes
// half-integer ratios. An odd q2_i alternates floor and ceil periods, and the
// average ratio is then exact.
module ccg_half_div #(
    parameter int QW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [QW-1:0] q2_i,
    output logic          tick_o
);
    localparam int CW = QW - 1;

    logic [CW-1:0] cnt;
    logic          long_ph;
    logic [CW-1:0] len;

    assign len    = q2_i[QW-1:1] + {{(CW-1){1'b0}}, q2_i[0] & long_ph};
    assign tick_o = en_i && (cnt >= len - 1'b1);

    // Count input enables within the current short or long period
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (tick_o)  cnt <= '0;
        else if (en_i)    cnt <= cnt + 1'b1;
    end

    // Swap between floor and ceil periods for odd ratios
    always_ff @(posedge clk) begin
        if (!rst_n)       long_ph <= 1'b0;
        else if (tick_o)  long_ph <= q2_i[0] & ~long_ph;
    end
endmodule

// File: rtl/ccg_frame_seq.sv
// Module: frame sequencer. In master mode it counts oversampling ticks and
// drives primary and secondary syncs; in slave mode it classifies the
// falling edges of an external sync. Assumes over_i is even and nonzero.
module ccg_frame_seq #(
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick_i,
    input  logic [OW-1:0] over_i,
    input  logic          master_i,
    input  logic          ctrl_i,
    input  logic          ext_fs_n_i,
    output logic          fs_n_o,
    output logic          prim_o,
    output logic          sec_o
);
    logic [OW-1:0] fcnt;
    logic [OW-1:0] nxt;
    logic          ext_q;
    logic          ext_fall;
    logic          want_sec;
    logic          is_pri;
    logic          is_sec;

    assign nxt      = (fcnt >= over_i - 1'b1) ? '0 : fcnt + 1'b1;
    assign is_pri   = (nxt == '0);
    assign is_sec   = ctrl_i && (nxt == (over_i >> 1));
    assign ext_fall = ext_q && !ext_fs_n_i;

    // Frame position counter; starts at all ones so the first tick is primary
    always_ff @(posedge clk) begin
        if (!rst_n)                                  fcnt <= '1;
        else if (!master_i && ext_fall && !want_sec) fcnt <= '0;
        else if (os_tick_i)                          fcnt <= nxt;
    end

    // Previous external sync level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b1;
        else        ext_q <= ext_fs_n_i;
    end

    // Slave mode primary/secondary alternation
    always_ff @(posedge clk) begin
        if (!rst_n)                      want_sec <= 1'b0;
        else if (!master_i && ext_fall)  want_sec <= ctrl_i && !want_sec;
        else if (!ctrl_i)                want_sec <= 1'b0;
    end

    // Sync output and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_n_o <= 1'b1;
            prim_o <= 1'b0;
            sec_o  <= 1'b0;
        end else if (master_i) begin
            prim_o <= os_tick_i && is_pri;
            sec_o  <= os_tick_i && is_sec;
            if (os_tick_i) fs_n_o <= !(is_pri || is_sec);
        end else begin
            fs_n_o <= 1'b1;
            prim_o <= ext_fall && !(ctrl_i && want_sec);
            sec_o  <= ext_fall && ctrl_i && want_sec;
        end
    end
endmodule

// File: rtl/codec_clkgen.sv
// Module: codec clock and frame generator top. It chains the M divider, the
// half-integer Q divider and the frame sequencer. Everything runs on the
// master clock; the shift clock is the os_tick enable.
module codec_clkgen #(
    parameter int MW = 3,
    parameter int QW = 5,
    parameter int OW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xtal_mode,
    input  logic        master,
    input  logic        ctrl_mode,
    input  logic [15:0] cfg_word,
    input  logic        cfg_load,
    input  logic        ext_fs_n,
    output logic        os_tick,
    output logic        fs_n,
    output logic        prim_strobe,
    output logic        sec_strobe
);
    logic [MW-1:0] m_val;
    logic [QW-1:0] q2_val;
    logic [OW-1:0] over_val;
    logic          m_tick;
    logic          q_tick;

    ccg_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .word_i(cfg_word),
        .m_o(m_val), .q2_o(q2_val), .over_o(over_val)
    );

    ccg_int_div #(.W(MW)) u_mdiv (
        .clk(clk), .rst_n(rst_n), .en_i(rst_n), .div_i(m_val), .tick_o(m_tick)
    );

    ccg_half_div #(.QW(QW)) u_qdiv (
        .clk(clk), .rst_n(rst_n), .en_i(m_tick), .q2_i(q2_val), .tick_o(q_tick)
    );

    assign os_tick = rst_n && (xtal_mode ? q_tick : 1'b1);

    ccg_frame_seq #(.OW(OW)) u_frame (
        .clk(clk), .rst_n(rst_n), .os_tick_i(os_tick), .over_i(over_val),
        .master_i(master), .ctrl_i(ctrl_mode), .ext_fs_n_i(ext_fs_n),
        .fs_n_o(fs_n), .prim_o(prim_strobe), .sec_o(sec_strobe)
    );
endmodule

// File: rtl/codec_clkgen_chk.sv
// Module: property checker for codec_clkgen, attached with bind.
module codec_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic ctrl_mode,
    input logic os_tick,
    input logic fs_n,
    input logic prim_strobe,
    input logic sec_strobe
);
    assert_pri_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master && prim_strobe) |-> !fs_n);

    assert_fs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $past(master) && !$past(os_tick)) |-> $stable(fs_n));

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(prim_strobe && sec_strobe));

    assert_no_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ctrl_mode) && !ctrl_mode) |-> !sec_strobe);

    assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!master) && !master) |-> fs_n);
endmodule

bind codec_clkgen codec_clkgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(master), .ctrl_mode(ctrl_mode),
    .os_tick(os_tick), .fs_n(fs_n), .prim_strobe(prim_strobe),
    .sec_strobe(sec_strobe)
);

// File: tb/codec_clkgen_tb_top.sv
module codec_clkgen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_mode = 1'b1;
    logic        master = 1'b1;
    logic        ctrl_mode = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        cfg_load = 1'b0;
    logic        ext_fs_n = 1'b1;
    logic        os_tick, fs_n, prim_strobe, sec_strobe;

    int total = 0;
    int bad = 0;
    longint cyc = 0;
    int prim_cnt = 0;
    int sec_cnt = 0;
    int fslow_cnt = 0;

    codec_clkgen dut_i (
        .clk(clk), .rst_n(rst_n), .xtal_mode(xtal_mode), .master(master),
        .ctrl_mode(ctrl_mode), .cfg_word(cfg_word), .cfg_load(cfg_load),
        .ext_fs_n(ext_fs_n), .os_tick(os_tick), .fs_n(fs_n),
        .prim_strobe(prim_strobe), .sec_strobe(sec_strobe)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (rst_n) begin
        if (prim_strobe) prim_cnt++;
        if (sec_strobe)  sec_cnt++;
        if (!fs_n)       fslow_cnt++;
    end

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [2:0] m, input logic [2:0] q, input logic [2:0] o);
        logic [15:0] w = '0;
        w[13] = m[2]; w[12] = m[1]; w[8] = m[0];
        w[11:9] = q;
        w[5:3] = o;
        return w;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(input logic [15:0] w);
        @(negedge clk);
        cfg_word = w;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_os(output longint t);
        do @(negedge clk); while (!os_tick);
        t = cyc;
    endtask

    task automatic wait_prim(output longint t);
        do @(negedge clk); while (!prim_strobe);
        t = cyc;
    endtask

    task automatic wait_sec(output longint t);
        do @(negedge clk); while (!sec_strobe);
        t = cyc;
    endtask

    task automatic ext_pulse();
        @(negedge clk);
        ext_fs_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_fs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    int m_tab[4] = '{3, 4, 1, 2};
    logic [2:0] mc_tab[4] = '{3'b000, 3'b001, 3'b110, 3'b111};
    int o_tab[5] = '{160, 192, 64, 96, 128};
    logic [2:0] oc_tab[5] = '{3'b000, 3'b001, 3'b101, 3'b110, 3'b111};

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint t0, t1, t2, d1, d2;
        int p0, s0;

        // R12: idle outputs during reset
        repeat (2) @(negedge clk);
        check("R12 os_tick in reset", os_tick, 0);
        check("R12 fs_n in reset", fs_n, 1);
        check("R12 strobes in reset", prim_strobe | sec_strobe, 0);
        do_reset();

        // R7, R8, R9: defaults in crystal master mode, no control mode
        wait_os(t0); wait_os(t1);
        check("R7 default tick interval", t1 - t0, 24);
        wait_prim(t0);
        check("R8 fs_n low with primary", fs_n, 0);
        do @(negedge clk); while (!fs_n);
        check("R8 fs_n low length", cyc - t0, 24);
        s0 = sec_cnt;
        wait_prim(t1);
        check("R7 default frame period", t1 - t0, 3840);
        check("R9 no secondary without control mode", sec_cnt - s0, 0);

        // R1-R4: sweep all valid M and Q codes
        for (int mi = 0; mi < 4; mi++) begin
            for (int qc = 0; qc < 8; qc++) begin
                int q2, lo, hi;
                q2 = (qc >= 4) ? (9 + 2 * (qc - 4)) : (10 + 2 * qc);
                lo = m_tab[mi] * (q2 / 2);
                hi = m_tab[mi] * ((q2 + 1) / 2);
                load(mk(mc_tab[mi], 3'(qc), 3'b000));
                repeat (3) wait_os(t0);
                wait_os(t0); wait_os(t1); wait_os(t2);
                d1 = t1 - t0; d2 = t2 - t1;
                check("R1 R3 R4 pair sum", d1 + d2, m_tab[mi] * q2);
                check("R2 interval is floor or ceil",
                      ((d1 == lo) || (d1 == hi)) && ((d2 == lo) || (d2 == hi)), 1);
                check("R2 alternation", d1 != d2, q2 % 2);
            end
        end

        // R11: reserved M code keeps M, Q field still loads
        load(mk(3'b000, 3'b001, 3'b000));
        load(mk(3'b010, 3'b000, 3'b000));
        repeat (3) wait_os(t0);
        wait_os(t0); wait_os(t1); wait_os(t2);
        check("R11 reserved M ignored", t2 - t0, 30);

        // R5, R6, R9: external clock mode, control mode on
        rst_n = 1'b0;
        xtal_mode = 1'b0;
        ctrl_mode = 1'b1;
        do_reset();
        @(negedge clk);
        check("R6 tick every cycle", os_tick, 1);
        wait_os(t0); wait_os(t1);
        check("R6 tick interval", t1 - t0, 1);
        for (int oi = 0; oi < 5; oi++) begin
            load(mk(3'b001, 3'b001, oc_tab[oi]));
            wait_prim(t0);
            wait_prim(t0);
            wait_sec(t1);
            wait_prim(t2);
            check("R9 primary to secondary", t1 - t0, o_tab[oi] / 2);
            check("R5 frame period", t2 - t0, o_tab[oi]);
        end
        // R11: reserved oversampling code after 64
        load(mk(3'b001, 3'b001, 3'b101));
        load(mk(3'b001, 3'b001, 3'b010));
        wait_prim(t0); wait_prim(t0); wait_prim(t1);
        check("R11 reserved OVER ignored", t1 - t0, 64);

        // R10: slave mode
        rst_n = 1'b0;
        master = 1'b0;
        do_reset();
        f0_block: begin
            int f0;
            f0 = fslow_cnt;
            p0 = prim_cnt; s0 = sec_cnt;
            ext_pulse();
            check("R10 first edge primary", prim_cnt - p0, 1);
            check("R10 first edge not secondary", sec_cnt - s0, 0);
            ext_pulse();
            check("R10 second edge secondary", sec_cnt - s0, 1);
            ext_pulse();
            check("R10 third edge primary", prim_cnt - p0, 2);
            ctrl_mode = 1'b0;
            repeat (2) @(negedge clk);
            ext_pulse();
            ext_pulse();
            check("R10 no control all primary", prim_cnt - p0, 4);
            check("R10 no control no secondary", sec_cnt - s0, 1);
            check("R10 fs_n stays high", fslow_cnt - f0, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule